// File: doc/BRIEF.md
# Composite Sync Separator with Vertical Detection

This block splits a composite sync stream into horizontal and vertical sync events. It receives one sync flag per clock: high while the incoming video is at sync level, low otherwise. Every rising edge of that flag is a horizontal sync request. The exception is when an external timebase reports, on `near_vsync`, that the frame is close to its expected vertical sync point. Edges in that window are ignored, so equalising pulses do not disturb horizontal lock.

Vertical sync is detected by integration. The block counts cycles from the first sync sample of a run of pulses. Short non-sync gaps between the pulses are counted too. When the total reaches a programmable threshold on a sync sample, a vertical sync request is issued in that same cycle. The detector then stays locked out until the line has been quiet for longer than a quarter line.

The threshold comes from two runtime inputs: the line length in clock cycles, and the expected vertical sync length in half-lines. Typical half-line values are 5 for 50 Hz video and 6 for 60 Hz video.

Top module: `csync_sep`

## Requirements
- R1: The vertical threshold T equals (vsync_half_lines × cycles_per_line) >> 1 cycles. A vertical sync request is issued for the sync sample at which the accumulated count first reaches T. The count includes that sample and begins at 1 on the first sync sample of an accumulation.
- R2: Once accumulation has started, every sample is counted. This includes non-sync samples in gaps of at most Q = cycles_per_line >> 2 consecutive cycles.
- R3: A non-sync run longer than Q consecutive cycles clears the accumulated count and ends accumulation. A later sync sample starts counting again from 1.
- R4: After a vertical sync request, no further vertical request is issued until a non-sync run longer than Q cycles has been seen, however much sync follows.
- R5: A horizontal sync request is issued for a sample that is sync when the previous sample was not sync, and only while near_vsync is low for that sample.
- R6: hsync_req and vsync_req are registered. Each is high for exactly one clock, in the cycle after the sample that caused it.
- R7: hsync_req and vsync_req are never high together. When one sample would cause both, only vsync_req is issued.
- R8: A synchronous active-high reset drives both outputs low and clears all counting state. The sample before reset counts as non-sync, so sync present at the first sample after reset produces a horizontal request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sync sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | 1 = video is at sync level this cycle |
| near_vsync | input | 1 | 1 = frame timebase is near its expected vertical sync; masks horizontal requests |
| cycles_per_line | input | 12 | Line length in clock cycles |
| vsync_half_lines | input | 4 | Expected vertical sync length in half-lines |
| hsync_req | output | 1 | One-cycle horizontal sync request |
| vsync_req | output | 1 | One-cycle vertical sync request |

## Verification
Both results appear exactly one clock after the sample that causes them. The bench therefore tags each sample with an index when it drives it. At the next falling edge it reads the outputs and credits any pulse to the previous index. It records the index of every vertical request and the count of horizontal ones. It compares these with sample indices computed from T, Q and the pulse-train geometry: the first sync sample at or beyond offset T−1 from the start of the broad pulses. Lockout and gap limits are probed with non-sync runs of exactly Q and Q+1 cycles.

// File: rtl/csync_pkg.sv
package csync_pkg;

    localparam int DEF_LINE_W = 12;
    localparam int DEF_HALF_W = 4;

    // events produced for one sample
    typedef struct packed {
        logic hs;
        logic vs;
    } sync_evt_t;

    // phase of the vertical integrator
    typedef enum logic [1:0] {
        VI_IDLE    = 2'd0,
        VI_COUNT   = 2'd1,
        VI_LOCKED  = 2'd2
    } vi_phase_t;

endpackage

// File: rtl/csync_edge.sv
module csync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic mask,
    output logic lead_hs
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_in;
    end

    assign lead_hs = sync_in & ~prev_q & ~mask;
endmodule

// File: rtl/csync_vacc.sv
module csync_vacc #(
    parameter int LINE_W = csync_pkg::DEF_LINE_W,
    parameter int ACC_W  = csync_pkg::DEF_LINE_W + csync_pkg::DEF_HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic [LINE_W-1:0] quarter,
    input  logic [ACC_W-1:0]  thresh,
    output logic              fire
);
    import csync_pkg::*;

    vi_phase_t          phase_q, phase_n;
    logic [ACC_W-1:0]   cnt_q, cnt_n;
    logic [LINE_W-1:0]  gap_q, gap_n;
    logic               expire;
    vi_phase_t          phase_e;
    logic [ACC_W-1:0]   cnt_e, cnt_inc;

    always_comb begin
        // quiet-run counter, saturating
        gap_n  = sync_in ? '0 : ((&gap_q) ? gap_q : gap_q + 1'b1);
        expire = !sync_in && (gap_n > quarter);

        // apply gap expiry first, then sync entry
        phase_e = expire ? VI_IDLE : phase_q;
        cnt_e   = expire ? '0 : cnt_q;
        if (sync_in && phase_e == VI_IDLE) phase_e = VI_COUNT;

        cnt_inc = (&cnt_e) ? cnt_e : cnt_e + 1'b1;
        phase_n = phase_e;
        cnt_n   = cnt_e;
        fire    = 1'b0;
        if (phase_e == VI_COUNT) begin
            cnt_n = cnt_inc;
            if (sync_in && cnt_inc >= thresh) begin
                fire    = 1'b1;
                cnt_n   = '0;
                phase_n = VI_LOCKED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= VI_IDLE;
            cnt_q   <= '0;
            gap_q   <= '0;
        end else begin
            phase_q <= phase_n;
            cnt_q   <= cnt_n;
            gap_q   <= gap_n;
        end
    end
endmodule

// File: rtl/csync_sep.sv
module csync_sep #(
    parameter int LINE_W = csync_pkg::DEF_LINE_W,
    parameter int HALF_W = csync_pkg::DEF_HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic              near_vsync,
    input  logic [LINE_W-1:0] cycles_per_line,
    input  logic [HALF_W-1:0] vsync_half_lines,
    output logic              hsync_req,
    output logic              vsync_req
);
    import csync_pkg::*;

    localparam int ACC_W = LINE_W + HALF_W;

    logic [ACC_W-1:0]  product, thresh;
    logic [LINE_W-1:0] quarter;
    logic              lead_hs, v_fire;
    sync_evt_t         evt_n, evt_q;

    assign product = ACC_W'(vsync_half_lines) * ACC_W'(cycles_per_line);
    assign thresh  = product >> 1;
    assign quarter = cycles_per_line >> 2;

    csync_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .mask    (near_vsync),
        .lead_hs (lead_hs)
    );

    csync_vacc #(.LINE_W(LINE_W), .ACC_W(ACC_W)) u_vacc (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .quarter (quarter),
        .thresh  (thresh),
        .fire    (v_fire)
    );

    // vertical wins when one sample raises both
    assign evt_n.vs = v_fire;
    assign evt_n.hs = lead_hs & ~v_fire;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_n;
    end

    assign hsync_req = evt_q.hs;
    assign vsync_req = evt_q.vs;
endmodule

// File: rtl/csync_sep_chk.sv
module csync_sep_chk #(
    parameter int LINE_W = csync_pkg::DEF_LINE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_in,
    input logic              near_vsync,
    input logic [LINE_W-1:0] cycles_per_line,
    input logic              hsync_req,
    input logic              vsync_req
);
    logic [LINE_W-1:0] low_run, low_nx;
    logic              locked, quiet_now;

    assign low_nx    = sync_in ? '0 : ((&low_run) ? low_run : low_run + 1'b1);
    assign quiet_now = !sync_in && (low_nx > (cycles_per_line >> 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
            locked  <= 1'b0;
        end else begin
            low_run <= low_nx;
            if (quiet_now)      locked <= 1'b0;
            else if (vsync_req) locked <= 1'b1;
        end
    end

    // R7
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hsync_req && vsync_req));
    // R6
    a_r6_hs_single: assert property (@(posedge clk) disable iff (rst)
        hsync_req |=> !hsync_req);
    a_r6_vs_single: assert property (@(posedge clk) disable iff (rst)
        vsync_req |=> !vsync_req);
    // R5
    a_r5_hs_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_req) |-> ($past(sync_in) && !$past(near_vsync)));
    // R1
    a_r1_vs_on_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_req) |-> $past(sync_in));
    // R4
    a_r4_lockout: assert property (@(posedge clk) disable iff (rst)
        vsync_req |-> !locked);
    // R8
    a_r8_reset_quiet: assert property (@(posedge clk)
        $fell(rst) |-> (!hsync_req && !vsync_req));
endmodule

bind csync_sep csync_sep_chk #(.LINE_W(LINE_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .sync_in         (sync_in),
    .near_vsync      (near_vsync),
    .cycles_per_line (cycles_per_line),
    .hsync_req       (hsync_req),
    .vsync_req       (vsync_req)
);

// File: tb/csync_sep_bench.sv
module csync_sep_bench;

    typedef struct packed {
        int cpl;
        int half;
        int bs;
        int bl;
        int nb;
    } scen_t;

    // line length, half-lines, broad sync/gap length, broad pulse count
    localparam scen_t SCN [5] = '{
        '{64, 5, 27, 5, 6},
        '{64, 6, 27, 5, 7},
        '{60, 5, 28, 2, 6},
        '{80, 6, 36, 4, 7},
        '{64, 5, 40, 8, 4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_in = 1'b0;
    logic        near = 1'b0;
    logic [11:0] cpl = 12'd64;
    logic [3:0]  half = 4'd5;
    logic        hs, vs;

    int idx, hs_cnt, vs_cnt, hs_last, vs_last, vs_first, both;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    csync_sep u_csync_sep (
        .clk(clk), .rst(rst), .sync_in(sync_in), .near_vsync(near),
        .cycles_per_line(cpl), .vsync_half_lines(half),
        .hsync_req(hs), .vsync_req(vs)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        hs_cnt = 0; vs_cnt = 0; hs_last = -1; vs_last = -1; vs_first = -1; both = 0;
    endtask

    // outputs seen here belong to sample idx-1
    task automatic step(input logic s, input logic n);
        @(negedge clk);
        if (hs) begin hs_cnt++; hs_last = idx - 1; end
        if (vs) begin
            if (vs_cnt == 0) vs_first = idx - 1;
            vs_cnt++; vs_last = idx - 1;
        end
        if (hs && vs) both++;
        sync_in = s; near = n; idx++;
    endtask

    task automatic pulses(input int s, input int l, input int n, input logic nv);
        repeat (n) begin
            repeat (s) step(1'b1, nv);
            repeat (l) step(1'b0, nv);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst = 1'b1; sync_in = s; near = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 hsync in reset", int'(hs), 0);
        chk("R8 vsync in reset", int'(vs), 0);
        rst = 1'b0;
        idx = 1;          // sample 0 is the value already on sync_in
        clr();
    endtask

    function automatic int exp_off(input int thr, input int bs, input int bl, input int nb);
        int h = bs + bl;
        for (int o = (thr > 0) ? thr - 1 : 0; o < nb * h; o++)
            if ((o % h) < bs) return o;
        return -1000000;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, s1, bstart, thr;

        // table of field trains, one loop
        for (int k = 0; k < 5; k++) begin
            cpl  = 12'(SCN[k].cpl);
            half = 4'(SCN[k].half);
            do_reset(1'b0);
            repeat (8) step(1'b0, 1'b0);
            pulses(5, SCN[k].cpl - 5, 4, 1'b0);
            pulses(2, SCN[k].cpl / 2 - 2, 3, 1'b1);
            bstart = idx;
            pulses(SCN[k].bs, SCN[k].bl, SCN[k].nb, 1'b1);
            pulses(2, SCN[k].cpl / 2 - 2, 3, 1'b1);
            pulses(5, SCN[k].cpl - 5, 4, 1'b0);
            step(1'b0, 1'b0); step(1'b0, 1'b0);
            thr = (SCN[k].half * SCN[k].cpl) / 2;
            chk("R4 one vsync per field", vs_cnt, 1);
            chk("R1 vsync sample", vs_last, bstart + exp_off(thr, SCN[k].bs, SCN[k].bl, SCN[k].nb));
            chk("R5 hsync count masked field", hs_cnt, 8);
            chk("R7 no overlap in field", both, 0);
        end

        // R8: sync already present at reset release is a leading edge
        cpl = 12'd64; half = 4'd5;
        do_reset(1'b1);
        repeat (4) step(1'b1, 1'b0);
        repeat (60) step(1'b0, 1'b0);
        chk("R8 edge after reset count", hs_cnt, 1);
        chk("R8 edge after reset sample", hs_last, 0);

        // R5 / R6: mask and single-cycle width
        clr();
        pulses(5, 59, 1, 1'b1);
        chk("R5 masked edge", hs_cnt, 0);
        s0 = idx;
        pulses(5, 59, 1, 1'b0);
        step(1'b0, 1'b0);
        chk("R6 one hsync cycle per pulse", hs_cnt, 1);
        chk("R5 hsync sample", hs_last, s0);

        // R2: ordinary lines never reach the vertical threshold
        clr();
        pulses(5, 59, 50, 1'b0);
        step(1'b0, 1'b0);
        chk("R2 no vsync from line pulses", vs_cnt, 0);
        chk("R5 hsync per line", hs_cnt, 50);

        // R4 / R3: lockout, Q-long gap keeps it, Q+1 releases it (T=32, Q=16)
        half = 4'd1;
        do_reset(1'b0);
        repeat (20) step(1'b0, 1'b0);
        s0 = idx;
        repeat (72) step(1'b1, 1'b0);
        repeat (16) step(1'b0, 1'b0);
        repeat (40) step(1'b1, 1'b0);
        repeat (17) step(1'b0, 1'b0);
        s1 = idx;
        repeat (40) step(1'b1, 1'b0);
        repeat (20) step(1'b0, 1'b0);
        chk("R4 vsync count with lockout", vs_cnt, 2);
        chk("R1 first crossing sample", vs_first, s0 + 31);
        chk("R3 crossing after release", vs_last, s1 + 31);

        // R2: gap of exactly Q keeps counting (T=64)
        half = 4'd2;
        do_reset(1'b0);
        repeat (20) step(1'b0, 1'b0);
        s0 = idx;
        repeat (30) step(1'b1, 1'b0);
        repeat (16) step(1'b0, 1'b0);
        repeat (30) step(1'b1, 1'b0);
        repeat (20) step(1'b0, 1'b0);
        chk("R2 gap counted vsync count", vs_cnt, 1);
        chk("R2 gap counted vsync sample", vs_last, s0 + 63);

        // R3: gap of Q+1 discards the count
        do_reset(1'b0);
        repeat (20) step(1'b0, 1'b0);
        repeat (30) step(1'b1, 1'b0);
        repeat (17) step(1'b0, 1'b0);
        repeat (30) step(1'b1, 1'b0);
        repeat (20) step(1'b0, 1'b0);
        chk("R3 count cleared no vsync", vs_cnt, 0);

        // R7: zero threshold fires on the leading edge, vertical wins
        half = 4'd0;
        do_reset(1'b0);
        repeat (20) step(1'b0, 1'b0);
        s0 = idx;
        repeat (3) step(1'b1, 1'b0);
        repeat (20) step(1'b0, 1'b0);
        chk("R7 vsync on edge sample", vs_last, s0);
        chk("R7 hsync suppressed", hs_cnt, 0);
        chk("R4 single vsync in pulse", vs_cnt, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule